// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

A watchdog counter that a system must restart at regular intervals. Software reaches it through a small register port with two registers, a control word and a status word. Both the control word and the counter restart are guarded by magic values, so a runaway program that scribbles over the register space is unlikely to reprogram or feed the watchdog by accident. To change the control word, software writes two unlock values and then the new word. To restart the counter, it writes two different restart values to the same control address.

When counting is enabled, the timeout is a power of two of input clocks. The exponent is selectable from 25 to 30, which is roughly one to thirty-two seconds at a clock near 33 MHz. A parameter `SCALE` subtracts a fixed amount from the exponent so that short timeouts can be used in simulation.

On expiry the block does one of two things, chosen by a bit in the control word. It either asks for a system reset with a one-cycle pulse and records the cause in the status word, or it raises a sticky interrupt. The status word also keeps flags for other reset causes, which are fed in as pulses from outside the block. Every status flag is cleared by writing a one to its bit.

Top module: `keyed_wdt`

## Requirements
- R1: The control register at address 0 takes a written word only when that write comes straight after a write of 0x3333 and then a write of 0xCCCC, both to address 0. A control write without this unlock leaves the register unchanged. Clock cycles with no write between the steps do not break the sequence.
- R2: A write at either key step that does not carry the expected key returns the key tracker to idle. So does any write to another address. A later attempt needs a complete new sequence.
- R3: A write of 0xAAAA followed by a write of 0x5555 to address 0 restarts the counter at zero. The restart keys leave the control word unchanged.
- R4: Control word layout: bit 15 is count enable, bit 14 is reset-on-expiry, and bits 4:0 are the exponent. A written exponent below 25 is stored as 25 and one above 30 is stored as 30. All other bits read as zero. After reset the control word reads 0x401E (counting off, reset-on-expiry on, exponent 30).
- R5: With count enable set, expiry occurs 2^(exponent−SCALE) clocks after the last restart. Committing a control word also restarts the counter. With count enable clear, the counter holds at zero and never expires.
- R6: On expiry with reset-on-expiry set, `rst_req_o` is high for exactly one cycle and status bit 0 is set.
- R7: On expiry with reset-on-expiry clear, status bit 1 is set and `irq_o` follows it and stays high until cleared. `rst_req_o` stays low.
- R8: The status register is at address 1. Bits 2 and up are set by pulses on `cause_i[k]`, which sets bit 2+k. Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A set in the same cycle as a clear wins.
- R9: Reading either register has no side effect and does not disturb a key sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 control, 1 status) |
| wdata_i | input | 16 | Write data |
| cause_i | input | NCAUSE | Pulses that set the external reset-cause flags |
| rdata_o | output | 16 | Read data for `addr_i` |
| rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | Timeout interrupt, sticky until cleared |

## Verification
Assertions check every cycle that:
- the control word changes only in the cycle after a committed unlock, and the stored exponent stays within 25..30;
- a restart zeroes the counter, and the counter never passes its terminal value;
- the reset request never lasts two cycles, and an interrupt never rises while reset-on-expiry is set;
- a watchdog status flag falls only after a write of one to its bit.

Some behaviour only the directed scenarios can show:
- the exact expiry cycle for each exponent;
- that broken key sequences and stray writes are ignored;
- that a read in the middle of a sequence leaves it intact;
- the set-over-clear priority of the external cause flags.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int unsigned DW    = 16;
  localparam int unsigned AW    = 2;
  localparam int unsigned EXP_W = 5;
  localparam int unsigned EXP_LO = 25;
  localparam int unsigned EXP_HI = 30;
  localparam int unsigned EN_BIT  = 15;
  localparam int unsigned RST_BIT = 14;

  localparam logic [DW-1:0] KEY_UNL_A = 16'h3333;
  localparam logic [DW-1:0] KEY_UNL_B = 16'hCCCC;
  localparam logic [DW-1:0] KEY_REF_A = 16'hAAAA;
  localparam logic [DW-1:0] KEY_REF_B = 16'h5555;

  localparam logic [AW-1:0] ADDR_CTRL = 2'd0;
  localparam logic [AW-1:0] ADDR_STAT = 2'd1;

  typedef enum logic [1:0] {KS_IDLE, KS_UNL1, KS_OPEN, KS_REF1} key_st_e;

  typedef struct packed {
    logic             en;
    logic             rst_en;
    logic [EXP_W-1:0] exp;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{en: 1'b0, rst_en: 1'b1, exp: EXP_W'(EXP_HI)};

  function automatic logic [EXP_W-1:0] clamp_exp(input logic [EXP_W-1:0] v);
    if (v < EXP_W'(EXP_LO)) return EXP_W'(EXP_LO);
    if (v > EXP_W'(EXP_HI)) return EXP_W'(EXP_HI);
    return v;
  endfunction
endpackage

// File: rtl/kwdt_key_fsm.sv
module kwdt_key_fsm
  import kwdt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_ctrl_i,
  input  logic          wr_other_i,
  input  logic [DW-1:0] wdata_i,
  output logic          commit_o,
  output logic          refresh_o
);
  key_st_e st_q, st_d;

  always_comb begin
    st_d      = st_q;
    commit_o  = 1'b0;
    refresh_o = 1'b0;
    if (wr_other_i) begin
      st_d = KS_IDLE;
    end else if (wr_ctrl_i) begin
      unique case (st_q)
        KS_IDLE: begin
          if (wdata_i == KEY_UNL_A)      st_d = KS_UNL1;
          else if (wdata_i == KEY_REF_A) st_d = KS_REF1;
          else                           st_d = KS_IDLE;
        end
        KS_UNL1: st_d = (wdata_i == KEY_UNL_B) ? KS_OPEN : KS_IDLE;
        KS_OPEN: begin
          commit_o = 1'b1;
          st_d     = KS_IDLE;
        end
        KS_REF1: begin
          refresh_o = (wdata_i == KEY_REF_B);
          st_d      = KS_IDLE;
        end
        default: st_d = KS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= KS_IDLE;
    else         st_q <= st_d;

  // R2: a stray write to another register always drops the sequence
  p_other_breaks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_other_i |=> st_q == KS_IDLE);
  p_commit_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_o && refresh_o));
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import kwdt_pkg::*;
#(
  parameter int unsigned SCALE = 0  // must stay below EXP_LO
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic             restart_i,
  output logic             expire_o
);
  localparam int unsigned CW = EXP_HI - SCALE;
  localparam logic [EXP_W-1:0] SC5 = EXP_W'(SCALE);

  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          at_lim;

  // 2^sh - 1; sh == CW wraps to all ones
  assign lim    = (CW'(1) << (exp_i - SC5)) - CW'(1);
  assign at_lim = (cnt_q == lim);
  assign expire_o = en_i && at_lim && !restart_i;

  always_comb begin
    if (restart_i || !en_i || at_lim) cnt_d = '0;
    else                              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;

  p_restart_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == '0);
  p_cnt_within_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim);
  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
endmodule

// File: rtl/kwdt_status.sv
module kwdt_status #(
  parameter int unsigned NCAUSE = 3,
  localparam int unsigned SW = 2 + NCAUSE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_wdt_i,
  input  logic              set_irq_i,
  input  logic [NCAUSE-1:0] cause_i,
  input  logic              clr_we_i,
  input  logic [SW-1:0]     clr_data_i,
  output logic [SW-1:0]     st_o
);
  logic [SW-1:0] st_q, set_v, clr_v;

  assign set_v = {cause_i, set_irq_i, set_wdt_i};
  assign clr_v = clr_we_i ? clr_data_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= '0;
    else         st_q <= (st_q & ~clr_v) | set_v;

  assign st_o = st_q;

  p_wdt_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(st_q[0]) |-> $past(clr_we_i && clr_data_i[0]));
  p_irq_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(st_q[1]) |-> $past(clr_we_i && clr_data_i[1]));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwdt_pkg::*;
#(
  parameter int unsigned SCALE  = 0,
  parameter int unsigned NCAUSE = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [NCAUSE-1:0] cause_i,
  output logic [DW-1:0]     rdata_o,
  output logic              rst_req_o,
  output logic              irq_o
);
  localparam int unsigned SW = 2 + NCAUSE;

  logic  wr_ctrl, wr_other, commit, refresh, expire, rst_req_q;
  ctrl_t ctrl_q;
  logic [SW-1:0] st;

  assign wr_ctrl  = wr_en_i && (addr_i == ADDR_CTRL);
  assign wr_other = wr_en_i && (addr_i != ADDR_CTRL);

  kwdt_key_fsm u_key (
    .clk_i, .rst_ni,
    .wr_ctrl_i (wr_ctrl),
    .wr_other_i(wr_other),
    .wdata_i,
    .commit_o  (commit),
    .refresh_o (refresh)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ctrl_q <= CTRL_RST;
    else if (commit) begin
      ctrl_q.en     <= wdata_i[EN_BIT];
      ctrl_q.rst_en <= wdata_i[RST_BIT];
      ctrl_q.exp    <= clamp_exp(wdata_i[EXP_W-1:0]);
    end

  kwdt_counter #(.SCALE(SCALE)) u_cnt (
    .clk_i, .rst_ni,
    .en_i     (ctrl_q.en),
    .exp_i    (ctrl_q.exp),
    .restart_i(commit || refresh),
    .expire_o (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rst_req_q <= 1'b0;
    else         rst_req_q <= expire && ctrl_q.rst_en;

  kwdt_status #(.NCAUSE(NCAUSE)) u_st (
    .clk_i, .rst_ni,
    .set_wdt_i (expire && ctrl_q.rst_en),
    .set_irq_i (expire && !ctrl_q.rst_en),
    .cause_i,
    .clr_we_i  (wr_en_i && (addr_i == ADDR_STAT)),
    .clr_data_i(wdata_i[SW-1:0]),
    .st_o      (st)
  );

  assign rst_req_o = rst_req_q;
  assign irq_o     = st[1];

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CTRL) begin
      rdata_o[EN_BIT]      = ctrl_q.en;
      rdata_o[RST_BIT]     = ctrl_q.rst_en;
      rdata_o[EXP_W-1:0]   = ctrl_q.exp;
    end else if (addr_i == ADDR_STAT) begin
      rdata_o[SW-1:0] = st;
    end
  end

  p_ctrl_guarded_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_q) |-> $past(commit));
  p_exp_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.exp >= EXP_W'(EXP_LO) && ctrl_q.exp <= EXP_W'(EXP_HI));
  p_rst_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  p_irq_mode_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !$past(ctrl_q.rst_en));
endmodule

// File: tb/sim_keyed_wdt.sv
module sim_keyed_wdt;
  localparam int unsigned SC = 20;
  localparam int unsigned NC = 3;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0]    addr  = '0;
  logic [15:0]   wdata = '0;
  logic [NC-1:0] cause = '0;
  logic [15:0]   rdata;
  logic          rst_req, irq;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  keyed_wdt #(.SCALE(SC), .NCAUSE(NC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .cause_i(cause), .rdata_o(rdata),
    .rst_req_o(rst_req), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the following negedge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic unlock(input logic [15:0] v);
    wr(A_CTRL, 16'h3333); wr(A_CTRL, 16'hCCCC); wr(A_CTRL, v);
  endtask

  task automatic watch(input int n, output int hits);
    hits = 0;
    repeat (n) begin
      @(negedge clk);
      if (rst_req) hits++;
    end
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(A_CTRL, d); chk("R4 reset ctrl", d, 16'h401E);
    rd(A_STAT, d); chk("R8 reset status", d, 0);
    chk("R6 reset rst_req", rst_req, 0);
    chk("R7 reset irq", irq, 0);
  endtask

  task automatic t_locked();
    logic [15:0] d;
    @(negedge clk);
    wr(A_CTRL, 16'hC019);
    rd(A_CTRL, d); chk("R1 write without unlock ignored", d, 16'h401E);
    @(negedge clk);
    unlock(16'h4019);
    rd(A_CTRL, d); chk("R1 unlocked write taken", d, 16'h4019);
    @(negedge clk);
    unlock(16'h401E);
  endtask

  task automatic t_broken();
    logic [15:0] d;
    wr(A_CTRL, 16'h3333); wr(A_CTRL, 16'h1234); wr(A_CTRL, 16'hCCCC); wr(A_CTRL, 16'hC01A);
    rd(A_CTRL, d); chk("R2 wrong second key", d, 16'h401E);
    @(negedge clk);
    wr(A_CTRL, 16'h3333); wr(A_STAT, 16'h0000); wr(A_CTRL, 16'hCCCC); wr(A_CTRL, 16'hC01A);
    rd(A_CTRL, d); chk("R2 stray status write breaks", d, 16'h401E);
    @(negedge clk);
  endtask

  task automatic t_layout();
    logic [15:0] d;
    unlock(16'h0005);
    rd(A_CTRL, d); chk("R4 exponent low clamp", d, 16'h0019);
    @(negedge clk);
    unlock(16'h3FFF);
    rd(A_CTRL, d); chk("R4 exponent high clamp, spare bits zero", d, 16'h001E);
    @(negedge clk);
    unlock(16'h401E);
  endtask

  task automatic t_read_midseq();
    logic [15:0] d;
    wr(A_CTRL, 16'h3333);
    rd(A_STAT, d); rd(A_CTRL, d);
    repeat (3) @(negedge clk);
    wr(A_CTRL, 16'hCCCC);
    rd(A_CTRL, d); rd(A_STAT, d);
    @(negedge clk);
    wr(A_CTRL, 16'h001B);
    rd(A_CTRL, d); chk("R9 reads do not break sequence", d, 16'h001B);
    @(negedge clk);
    unlock(16'h401E);
  endtask

  task automatic t_timeouts();
    logic [15:0] d;
    int h;
    for (int n = 25; n <= 30; n++) begin
      unlock(16'hC000 | 16'(n));
      watch((1 << (n - SC)) - 1, h);
      chk($sformatf("R5 no early expiry exp %0d", n), h, 0);
      @(negedge clk);
      chk($sformatf("R5 expiry at 2^%0d clocks", n - SC), rst_req, 1);
      rd(A_STAT, d); chk("R6 status wdt flag", d[0], 1);
      @(negedge clk);
      chk("R6 one-cycle pulse", rst_req, 0);
      wr(A_STAT, 16'h0001);
      rd(A_STAT, d); chk("R8 write one clears", d, 0);
      @(negedge clk);
    end
    unlock(16'h401E);
  endtask

  task automatic t_refresh();
    logic [15:0] d;
    int h;
    unlock(16'hC019);
    repeat (20) @(negedge clk);
    wr(A_CTRL, 16'hAAAA); wr(A_CTRL, 16'h5555);
    watch(31, h); chk("R3 refresh postpones expiry", h, 0);
    @(negedge clk); chk("R3 expiry after refresh", rst_req, 1);
    rd(A_CTRL, d); chk("R3 refresh leaves ctrl", d, 16'hC019);
    @(negedge clk);
    wr(A_STAT, 16'h0001);
    unlock(16'hC019);
    repeat (10) @(negedge clk);
    wr(A_CTRL, 16'hAAAA); wr(A_CTRL, 16'h0000); wr(A_CTRL, 16'h5555);
    watch(18, h); chk("R2 broken refresh no early pulse", h, 0);
    @(negedge clk); chk("R2 broken refresh ignored", rst_req, 1);
    @(negedge clk);
    wr(A_STAT, 16'h0001);
    unlock(16'h401E);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    int h;
    unlock(16'h8019);
    watch(31, h); chk("R7 no reset pulse before", h, 0);
    @(negedge clk); chk("R7 irq raised", irq, 1);
    chk("R7 no reset request", rst_req, 0);
    watch(10, h); chk("R7 no reset request after", h, 0);
    chk("R7 irq sticky", irq, 1);
    rd(A_STAT, d); chk("R7 status irq flag", d, 16'h0002);
    @(negedge clk);
    wr(A_STAT, 16'h0000);
    rd(A_STAT, d); chk("R8 write zero no effect", d, 16'h0002);
    @(negedge clk);
    wr(A_STAT, 16'h0002);
    chk("R7 irq cleared", irq, 0);
    unlock(16'h401E);
  endtask

  task automatic t_disabled();
    logic [15:0] d;
    int h;
    unlock(16'h4019);
    watch(100, h); chk("R5 disabled never expires", h, 0);
    rd(A_STAT, d); chk("R5 disabled status clean", d, 0);
    chk("R5 disabled irq", irq, 0);
    @(negedge clk);
    unlock(16'h401E);
  endtask

  task automatic t_causes();
    logic [15:0] d;
    cause = 3'b101;
    @(negedge clk);
    cause = 3'b000;
    rd(A_STAT, d); chk("R8 cause flags set", d, 16'h0014);
    @(negedge clk);
    wr(A_STAT, 16'h0004);
    rd(A_STAT, d); chk("R8 selective clear", d, 16'h0010);
    @(negedge clk);
    cause = 3'b100;
    wr(A_STAT, 16'h0010);
    cause = 3'b000;
    rd(A_STAT, d); chk("R8 set wins over clear", d, 16'h0010);
    @(negedge clk);
    wr(A_STAT, 16'h0010);
    rd(A_STAT, d); chk("R8 cleared", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked();
    t_broken();
    t_layout();
    t_read_midseq();
    t_timeouts();
    t_refresh();
    t_irq();
    t_disabled();
    t_causes();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule